// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the four active-low control strobes of an asynchronous DRAM bus (row strobe, column strobe, write enable, output enable) from a system clock that runs much faster than the strobes. It works out which kind of memory cycle the controller performed from the order in which the strobes moved. Each completed cycle is reported once, as a single-clock pulse that carries a four-bit type code. The block can tell a normal read, an early write, a late write and a read-modify-write apart. It also separates the first column access of a row from the page accesses that follow it, and it tells row-only, column-before-row and hidden refresh apart from one another.

A sticky flag records breaches of the row-strobe timing. These are a row-active phase ended too soon, or a row precharge that was too short before the next row assertion. The block is meant to sit next to a DRAM controller as a protocol checker. Every strobe passes through a two-flop synchroniser, so the monitored bus may be fully asynchronous to the clock.

Reports are unconditional. The output has no ready signal and applies no back-pressure. A consumer must take each pulse in the cycle it appears, and at most one report appears in any clock.

Top module: `strobe_cycle_monitor`

## Requirements
- R1: After reset, `cyc_valid` is 0, `cyc_kind` is 0 and `proto_viol` is 0. Whenever `cyc_valid` is 1, `cyc_kind` is one of the codes 1 to 9.
- R2: The strobe edge that closes a cycle produces exactly one report. `cyc_valid` is high for exactly one clock, and it is first seen high three rising clock edges after the first rising edge at which the new strobe level is present at the input.
- R3: A column access whose write enable stays high is reported as read (code 1). The report is made when the column strobe rises, or when the row strobe rises first while the column strobe is still low.
- R4: A column access whose write enable is already low when the column strobe falls is reported as early write (code 2).
- R5: A column access in which write enable falls after the column strobe has fallen, with output enable not low beforehand, is reported as late write (code 3).
- R6: A column access in which output enable is low while write enable is still high, and write enable then falls, is reported as read-modify-write (code 4).
- R7: Within one row-active phase, the second and later column accesses are reported as page read (code 5) if no write took place, and as page write (code 6) otherwise.
- R8: A row-active phase that begins with the column strobe high and that sees no column-strobe fall is reported as row-only refresh (code 7) when the row strobe rises.
- R9: If the column strobe is already low when the row strobe falls, and it did not stay low from an earlier access, the cycle is reported as column-before-row refresh (code 8) when the row strobe rises.
- R10: If the row strobe rises while a column access is open, then falls again with the column strobe still held low, the cycle is reported as hidden refresh (code 9) when the row strobe rises.
- R11: A row-active phase lasting fewer than MIN_ROW_ACT clocks sets `proto_viol`. The cycle is still classified. `proto_viol` stays set until reset and is not set by phases that meet the limit.
- R12: A row strobe that falls after fewer than MIN_ROW_PRE clocks high sets `proto_viol`. A precharge that meets the limit leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row address strobe, active low, asynchronous |
| col_stb_n | input | 1 | Column address strobe, active low, asynchronous |
| wr_en_n | input | 1 | Write enable, active low, asynchronous |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| cyc_valid | output | 1 | One-clock pulse marking a classified cycle |
| cyc_kind | output | 4 | Cycle type code (1 to 9), valid with `cyc_valid` |
| proto_viol | output | 1 | Sticky flag for row active or precharge breaches |

## Verification
A report or a violation is due on the third rising clock edge after a strobe change reaches the inputs: two edges in the synchroniser and one in the output register. The bench drives strobes after falling edges and samples at falling edges. In one row-only cycle it probes the second and the third falling edge after the closing edge, to pin that latency exactly. Every report is compared in order against a queue of expected codes as it appears. Each scenario then idles six clocks, which is longer than the latency, and confirms that the queue is empty before it reads the violation flag.

// File: rtl/scc_pkg.sv
package scc_pkg;

  // strobe line positions inside the packed pin vector
  localparam int STB_ROW     = 0;
  localparam int STB_COL     = 1;
  localparam int STB_WR      = 2;
  localparam int STB_OE      = 3;
  localparam int N_STROBES   = 4;
  // lines that need edge events (row and column only)
  localparam int N_EDGE_LINES = 2;

  typedef enum logic [3:0] {
    CK_NONE     = 4'd0,
    CK_READ     = 4'd1,
    CK_EARLY_WR = 4'd2,
    CK_LATE_WR  = 4'd3,
    CK_RMW      = 4'd4,
    CK_PAGE_RD  = 4'd5,
    CK_PAGE_WR  = 4'd6,
    CK_ROW_ONLY = 4'd7,
    CK_CBR      = 4'd8,
    CK_HIDDEN   = 4'd9
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACCESS,
    PH_REFRESH
  } row_phase_e;

  // type of a finished column access from the facts gathered while it was open
  function automatic cyc_kind_e access_kind(input logic early, input logic late,
                                            input logic rd, input logic page);
    cyc_kind_e k;
    if (page)       k = (early || late) ? CK_PAGE_WR : CK_PAGE_RD;
    else if (early) k = CK_EARLY_WR;
    else if (late)  k = rd ? CK_RMW : CK_LATE_WR;
    else            k = CK_READ;
    return k;
  endfunction

endpackage

// File: rtl/scc_strobe_sync.sv
module scc_strobe_sync #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_n,
  output logic [LINES-1:0] act
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= pin_n[i];
        sync_q <= meta_q;
      end
    end
    assign act[i] = ~sync_q;
  end

endmodule

// File: rtl/scc_edge_det.sv
module scc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic asr,
  output logic rel
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= act;
  end

  assign asr = act & ~prev_q;
  assign rel = ~act & prev_q;

endmodule

// File: rtl/scc_level_timer.sv
module scc_level_timer #(
  parameter int MIN_ACT = 6,
  parameter int MIN_PRE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asr,
  input  logic rel,
  output logic short_act,
  output logic short_pre
);

  localparam int CAP = (MIN_ACT > MIN_PRE) ? MIN_ACT : MIN_PRE;
  localparam int W   = $clog2(CAP + 1);

  // length of the current row level, saturating at CAP
  logic [W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= W'(CAP);
    end else if (asr || rel) begin
      len_q <= W'(1);
    end else if (len_q != W'(CAP)) begin
      len_q <= len_q + 1'b1;
    end
  end

  assign short_act = rel && (len_q < W'(MIN_ACT));
  assign short_pre = asr && (len_q < W'(MIN_PRE));

endmodule

// File: rtl/scc_classifier.sv
module scc_classifier
  import scc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      row_act,
  input  logic      col_act,
  input  logic      wr_act,
  input  logic      oe_act,
  input  logic      row_asr,
  input  logic      row_rel,
  input  logic      col_asr,
  input  logic      col_rel,
  output logic      rpt_valid,
  output cyc_kind_e rpt_kind
);

  row_phase_e phase_q;
  cyc_kind_e  ref_kind_q;
  logic       col_open_q;
  logic       wr_early_q;
  logic       wr_late_q;
  logic       rd_seen_q;
  logic       page_q;
  logic       col_held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      ref_kind_q <= CK_NONE;
      col_open_q <= 1'b0;
      wr_early_q <= 1'b0;
      wr_late_q  <= 1'b0;
      rd_seen_q  <= 1'b0;
      page_q     <= 1'b0;
      col_held_q <= 1'b0;
      rpt_valid  <= 1'b0;
      rpt_kind   <= CK_NONE;
    end else begin
      rpt_valid <= 1'b0;
      if (col_rel) col_held_q <= 1'b0;

      // facts gathered while a column access is open
      if (col_open_q && !wr_early_q && wr_act) wr_late_q <= 1'b1;
      if (col_open_q && oe_act && !wr_act && !wr_late_q) rd_seen_q <= 1'b1;

      unique case (phase_q)
        PH_IDLE: begin
          if (row_asr) begin
            if (col_act) begin
              phase_q    <= PH_REFRESH;
              ref_kind_q <= col_held_q ? CK_HIDDEN : CK_CBR;
            end else begin
              phase_q    <= PH_ACCESS;
              page_q     <= 1'b0;
              col_open_q <= 1'b0;
            end
          end
        end
        PH_ACCESS: begin
          if (col_open_q && (col_rel || row_rel)) begin
            rpt_valid  <= 1'b1;
            rpt_kind   <= access_kind(wr_early_q, wr_late_q, rd_seen_q, page_q);
            col_open_q <= 1'b0;
            page_q     <= 1'b1;
            if (row_rel && !col_rel) col_held_q <= 1'b1;
          end else if (!col_open_q && col_asr && !row_rel) begin
            col_open_q <= 1'b1;
            wr_early_q <= wr_act;
            wr_late_q  <= 1'b0;
            rd_seen_q  <= oe_act & ~wr_act;
          end else if (!col_open_q && row_rel && !page_q) begin
            rpt_valid <= 1'b1;
            rpt_kind  <= CK_ROW_ONLY;
          end
          if (row_rel) phase_q <= PH_IDLE;
        end
        PH_REFRESH: begin
          if (row_rel) begin
            rpt_valid <= 1'b1;
            rpt_kind  <= ref_kind_q;
            phase_q   <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_cycle_monitor.sv
module strobe_cycle_monitor
  import scc_pkg::*;
#(
  parameter int MIN_ROW_ACT = 6,
  parameter int MIN_ROW_PRE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_stb_n,
  input  logic       col_stb_n,
  input  logic       wr_en_n,
  input  logic       out_en_n,
  output logic       cyc_valid,
  output logic [3:0] cyc_kind,
  output logic       proto_viol
);

  logic [N_STROBES-1:0]    pins_n;
  logic [N_STROBES-1:0]    act;
  logic [N_EDGE_LINES-1:0] asr_ev;
  logic [N_EDGE_LINES-1:0] rel_ev;
  logic                    short_act, short_pre;
  cyc_kind_e               kind;
  logic                    viol_q;

  always_comb begin
    pins_n          = '1;
    pins_n[STB_ROW] = row_stb_n;
    pins_n[STB_COL] = col_stb_n;
    pins_n[STB_WR]  = wr_en_n;
    pins_n[STB_OE]  = out_en_n;
  end

  scc_strobe_sync #(.LINES(N_STROBES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (pins_n),
    .act   (act)
  );

  for (genvar g = 0; g < N_EDGE_LINES; g++) begin : g_edge
    scc_edge_det u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act[g]),
      .asr   (asr_ev[g]),
      .rel   (rel_ev[g])
    );
  end

  scc_level_timer #(.MIN_ACT(MIN_ROW_ACT), .MIN_PRE(MIN_ROW_PRE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .asr       (asr_ev[STB_ROW]),
    .rel       (rel_ev[STB_ROW]),
    .short_act (short_act),
    .short_pre (short_pre)
  );

  scc_classifier u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_act   (act[STB_ROW]),
    .col_act   (act[STB_COL]),
    .wr_act    (act[STB_WR]),
    .oe_act    (act[STB_OE]),
    .row_asr   (asr_ev[STB_ROW]),
    .row_rel   (rel_ev[STB_ROW]),
    .col_asr   (asr_ev[STB_COL]),
    .col_rel   (rel_ev[STB_COL]),
    .rpt_valid (cyc_valid),
    .rpt_kind  (kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_q | short_act | short_pre;
  end

  assign cyc_kind   = kind;
  assign proto_viol = viol_q;

endmodule

// File: rtl/strobe_cycle_monitor_chk.sv
module strobe_cycle_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       row_stb_n,
  input logic       col_stb_n,
  input logic       cyc_valid,
  input logic [3:0] cyc_kind,
  input logic       proto_viol
);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  // R1
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_kind != 4'd0 && cyc_kind <= 4'd9));

  // R11
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_viol |=> proto_viol);

  // R8
  refresh_on_row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind >= 4'd7) |-> ($past(row_stb_n, 3) && !$past(row_stb_n, 4)));

  // R3
  access_on_strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind >= 4'd1 && cyc_kind <= 4'd6) |->
      (($past(col_stb_n, 3) && !$past(col_stb_n, 4)) ||
       ($past(row_stb_n, 3) && !$past(row_stb_n, 4))));

endmodule

bind strobe_cycle_monitor strobe_cycle_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_stb_n  (row_stb_n),
  .col_stb_n  (col_stb_n),
  .cyc_valid  (cyc_valid),
  .cyc_kind   (cyc_kind),
  .proto_viol (proto_viol)
);

// File: tb/strobe_cycle_monitor_bench.sv
module strobe_cycle_monitor_bench;

  localparam int K_READ = 1, K_EARLY = 2, K_LATE = 3, K_RMW = 4;
  localparam int K_PRD = 5, K_PWR = 6, K_ROWONLY = 7, K_CBR = 8, K_HIDDEN = 9;
  localparam int WD_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic       cyc_valid;
  logic [3:0] cyc_kind;
  logic       proto_viol;

  int    checks = 0;
  int    failures = 0;
  int    wd = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  strobe_cycle_monitor u_strobe_cycle_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_stb_n  (row_n),
    .col_stb_n  (col_n),
    .wr_en_n    (wr_n),
    .out_en_n   (oe_n),
    .cyc_valid  (cyc_valid),
    .cyc_kind   (cyc_kind),
    .proto_viol (proto_viol)
  );

  function automatic void check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_kind(input int k, input string tag);
    exp_q.push_back(k);
    tag_q.push_back(tag);
  endtask

  task automatic drain(input string tag);
    idle(6);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // reference comparison on every clock: each report must match the next expectation
  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R2 unexpected report actual=%0d expected=none", cyc_kind);
      end else begin
        check(int'(cyc_kind) == exp_q[0], tag_q[0], int'(cyc_kind), exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT && !done) begin
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected=<%0d cycles", wd, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(cyc_valid == 1'b0, "R1 valid after reset", cyc_valid, 0);
    check(cyc_kind == 4'd0, "R1 kind after reset", cyc_kind, 0);
    check(proto_viol == 1'b0, "R1 viol after reset", proto_viol, 0);
    idle(4);

    // R3 plain read
    expect_kind(K_READ, "R3 read");
    row_n = 0; idle(2); col_n = 0; oe_n = 0; idle(3); col_n = 1; oe_n = 1; idle(3); row_n = 1;
    drain("R3 drain");

    // R4 early write
    expect_kind(K_EARLY, "R4 early write");
    row_n = 0; idle(2); wr_n = 0; idle(1); col_n = 0; idle(3); col_n = 1; wr_n = 1; idle(3); row_n = 1;
    drain("R4 drain");

    // R5 late write
    expect_kind(K_LATE, "R5 late write");
    row_n = 0; idle(2); col_n = 0; idle(2); wr_n = 0; idle(2); col_n = 1; wr_n = 1; idle(3); row_n = 1;
    drain("R5 drain");

    // R6 read-modify-write
    expect_kind(K_RMW, "R6 read-modify-write");
    row_n = 0; idle(2); col_n = 0; idle(1); oe_n = 0; idle(2); oe_n = 1; idle(1); wr_n = 0; idle(2);
    col_n = 1; wr_n = 1; idle(3); row_n = 1;
    drain("R6 drain");

    // R7 page accesses: read, page read, page write
    expect_kind(K_READ, "R7 first column");
    expect_kind(K_PRD, "R7 page read");
    expect_kind(K_PWR, "R7 page write");
    row_n = 0; idle(2);
    for (int i = 0; i < 2; i++) begin
      col_n = 0; oe_n = 0; idle(2); col_n = 1; oe_n = 1; idle(2);
    end
    wr_n = 0; idle(1); col_n = 0; idle(2); col_n = 1; wr_n = 1; idle(2); row_n = 1;
    drain("R7 drain");

    // R8 row-only refresh with exact latency probe (R2)
    expect_kind(K_ROWONLY, "R8 row-only refresh");
    row_n = 0; idle(8); row_n = 1;
    idle(2);
    check(cyc_valid == 1'b0, "R2 not yet at two edges", cyc_valid, 0);
    idle(1);
    check(cyc_valid == 1'b1 && cyc_kind == 4'd7, "R2 report at third edge",
          {cyc_valid, cyc_kind}, {1'b1, 4'd7});
    idle(1);
    check(cyc_valid == 1'b0, "R2 single clock pulse", cyc_valid, 0);
    drain("R8 drain");

    // R9 column-before-row refresh
    expect_kind(K_CBR, "R9 cbr refresh");
    col_n = 0; idle(2); row_n = 0; idle(7); row_n = 1; idle(2); col_n = 1;
    drain("R9 drain");

    // R10 hidden refresh after a read held open
    expect_kind(K_READ, "R10 read before hidden");
    expect_kind(K_HIDDEN, "R10 hidden refresh");
    row_n = 0; idle(2); col_n = 0; oe_n = 0; idle(4); row_n = 1; idle(5);
    row_n = 0; idle(7); row_n = 1; idle(2); col_n = 1; oe_n = 1;
    drain("R10 drain");

    // R11 / R12: legal timing left the flag clear
    check(proto_viol == 1'b0, "R11 no violation on legal cycles", proto_viol, 0);

    // R11 short row-active phase
    expect_kind(K_ROWONLY, "R11 short cycle still classified");
    row_n = 0; idle(3); row_n = 1;
    drain("R11 drain");
    check(proto_viol == 1'b1, "R11 short active sets flag", proto_viol, 1);
    expect_kind(K_ROWONLY, "R11 legal cycle after breach");
    row_n = 0; idle(8); row_n = 1;
    drain("R11 drain sticky");
    check(proto_viol == 1'b1, "R11 flag sticky", proto_viol, 1);
    do_reset();
    check(proto_viol == 1'b0, "R11 reset clears flag", proto_viol, 0);
    idle(4);

    // R12 short precharge
    expect_kind(K_ROWONLY, "R12 first cycle");
    expect_kind(K_ROWONLY, "R12 second cycle");
    row_n = 0; idle(7); row_n = 1; idle(2);
    check(proto_viol == 1'b0, "R12 no flag before breach", proto_viol, 0);
    row_n = 0; idle(7); row_n = 1;
    drain("R12 drain");
    check(proto_viol == 1'b1, "R12 short precharge sets flag", proto_viol, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule